// File: doc/BRIEF.md
# Bit-Line Coincidence Checker

This block watches the sense-amplifier outputs of a memory subarray during a parallel test. The bit lines are split into two interleaved groups, the even-indexed lines and the odd-indexed lines. In test mode one group is selected, and the same value has been written to every cell of that group on the active word line. When the group is read back, every selected bit should therefore carry the same value. The checker does not need the expected data. It only asks whether the selected bits are unanimous, using an all-ones detector and an all-zeros detector side by side. A read that mixes ones and zeros sets a sticky error flag. Because no reference value is involved, the check still works when a multiple-access decode fault makes the read path behave like a wired AND or a wired OR, and when several cells carry the same fault.

Each read is split into a precharge cycle and an evaluate cycle, and only an evaluate cycle can set the flag. Sense amplifiers can be slow to settle, so a programmable number of cycles at the start of every read phase is ignored. The flag is forced clear during the write phase, outside test mode, and by an explicit clear. The sense bus is sampled every cycle with no handshake. Every pin is a plain level and there is no back-pressure, because the block never stalls the memory and never queues a result.

Top module: `bit_coincidence_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `err_flag` is 0.
- R2: With `grp_even`=1 the comparator looks at sense bits 0, 2, 4, … (even indices). With `grp_even`=0 it looks at bits 1, 3, 5, … (odd indices).
- R3: If every selected bit is 1 during a checked evaluate cycle, `err_flag` is not set.
- R4: If every selected bit is 0 during a checked evaluate cycle, `err_flag` is not set.
- R5: If the selected bits mix ones and zeros in an evaluate cycle (`eval_phase`=1) of a read phase in test mode, and the settle window has expired, `err_flag` is 1 from the next clock edge.
- R6: The bits of the group that is not selected have no effect on `err_flag`.
- R7: Once set, `err_flag` stays 1 through later precharge and unanimous cycles of the same read phase.
- R8: `err_clr`=1 clears `err_flag` at the next edge, even when a mismatch is present in the same cycle.
- R9: In a write phase (`rd_phase`=0), `err_flag` is 0 from the next edge and cannot be set.
- R10: With `test_en`=0, `err_flag` is 0 from the next edge and cannot be set, so a new test always starts from a clear flag.
- R11: A precharge cycle (`eval_phase`=0) never sets `err_flag`.
- R12: The read age is 0 in the first cycle of a read phase and rises by one each cycle. A mismatch is ignored while the read age is below `settle_cycles`, so a value of 0 checks from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Parallel-test mode enable |
| rd_phase | input | 1 | 1 = read phase, 0 = write phase |
| eval_phase | input | 1 | 1 = evaluate/discharge, 0 = precharge |
| grp_even | input | 1 | Group select: 1 = even bit lines, 0 = odd bit lines |
| sense | input | NUM_BITS | Sense-amplifier outputs of the subarray |
| settle_cycles | input | SETTLE_W | Length of the ignored window at the start of each read phase |
| err_clr | input | 1 | Explicit clear of the error flag |
| err_flag | output | 1 | Sticky error flag |

## Verification
Two functions can act in the same cycle. A clear (explicit, write-phase or test-mode exit) can coincide with a mismatch that would set the flag, and a mismatch can arrive exactly on the cycle the settle window expires. The bench drives a mixed pattern together with `err_clr`, and separately with `rd_phase` or `test_en` low, and expects the flag to read 0 after the edge, because the clear takes precedence. It also runs a read phase with a nonzero window and holds a mismatch from the first cycle. The flag must stay 0 for exactly `settle_cycles` cycles and then rise on the edge that follows the first counted cycle.

// File: rtl/ucmp_pkg.sv
package ucmp_pkg;
  typedef enum logic {
    GRP_ODD  = 1'b0,
    GRP_EVEN = 1'b1
  } grp_sel_e;

  typedef struct packed {
    logic all_one;
    logic all_zero;
    logic mixed;
  } unan_t;
endpackage

// File: rtl/ucmp_group_mux.sv
module ucmp_group_mux
  import ucmp_pkg::*;
#(
  parameter int NUM_BITS = 16,
  localparam int HALF = NUM_BITS / 2
) (
  input  logic [NUM_BITS-1:0] sense,
  input  grp_sel_e            grp,
  output logic [HALF-1:0]     sel_bits
);
  logic [HALF-1:0] even_v;
  logic [HALF-1:0] odd_v;

  for (genvar g = 0; g < HALF; g++) begin : g_split
    assign even_v[g] = sense[2*g];
    assign odd_v[g]  = sense[2*g+1];
  end

  always_comb begin
    sel_bits = (grp == GRP_EVEN) ? even_v : odd_v;
  end
endmodule

// File: rtl/ucmp_unanimity.sv
module ucmp_unanimity
  import ucmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits,
  output unan_t            res
);
  logic ones_det;
  logic zeros_det;

  always_comb begin
    ones_det  = &bits;
    zeros_det = ~|bits;
    res.all_one  = ones_det;
    res.all_zero = zeros_det;
    res.mixed    = ~(ones_det | zeros_det);
  end
endmodule

// File: rtl/ucmp_settle_timer.sv
module ucmp_settle_timer #(
  parameter int CW = 4,
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          settled
);
  logic [CW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (!run) begin
      age_q <= '0;
    end else if (age_q != CNT_MAX) begin
      age_q <= age_q + 1'b1;
    end
  end

  always_comb begin
    settled = run && (age_q >= limit);
  end
endmodule

// File: rtl/ucmp_err_latch.sv
module ucmp_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clr,
  input  logic arm,
  input  logic mixed,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hold_clr) begin
      flag <= 1'b0;
    end else if (arm && mixed) begin
      flag <= 1'b1;
    end
  end
endmodule

// File: rtl/bit_coincidence_checker.sv
module bit_coincidence_checker
  import ucmp_pkg::*;
#(
  parameter int NUM_BITS = 16,
  parameter int SETTLE_W = 4,
  localparam int HALF = NUM_BITS / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_en,
  input  logic                rd_phase,
  input  logic                eval_phase,
  input  logic                grp_even,
  input  logic [NUM_BITS-1:0] sense,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                err_clr,
  output logic                err_flag
);
  logic [HALF-1:0] sel_bits;
  unan_t           unan;
  logic            settled;
  logic            read_run;
  logic            hold_clr;
  logic            arm;
  grp_sel_e        grp;

  always_comb begin
    grp      = grp_even ? GRP_EVEN : GRP_ODD;
    read_run = test_en && rd_phase;
    hold_clr = !read_run || err_clr;
    arm      = eval_phase && settled;
  end

  ucmp_group_mux #(.NUM_BITS(NUM_BITS)) u_mux (
    .sense    (sense),
    .grp      (grp),
    .sel_bits (sel_bits)
  );

  ucmp_unanimity #(.WIDTH(HALF)) u_unan (
    .bits (sel_bits),
    .res  (unan)
  );

  ucmp_settle_timer #(.CW(SETTLE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (read_run),
    .limit   (settle_cycles),
    .settled (settled)
  );

  ucmp_err_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_clr (hold_clr),
    .arm      (arm),
    .mixed    (unan.mixed),
    .flag     (err_flag)
  );
endmodule

// File: rtl/ucmp_checker.sv
module ucmp_checker #(
  parameter int NUM_BITS = 16,
  parameter int SETTLE_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                test_en,
  input logic                rd_phase,
  input logic                eval_phase,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                err_clr,
  input logic                err_flag
);
  logic [15:0] rd_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_age <= '0;
    else if (!(test_en && rd_phase)) rd_age <= '0;
    else if (rd_age != 16'hFFFF) rd_age <= rd_age + 16'd1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> !err_flag); // R1
  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !rd_phase |=> !err_flag); // R9
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !test_en |=> !err_flag); // R10
  AST_EXPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) err_clr |=> !err_flag); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && test_en && rd_phase && !err_clr) |=> err_flag); // R7
  AST_PRECHG_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !eval_phase) |=> !err_flag); // R11
  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(rd_age >= {{(16-SETTLE_W){1'b0}}, settle_cycles})); // R12
  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(test_en && rd_phase && eval_phase)); // R5
endmodule

bind bit_coincidence_checker ucmp_checker #(
  .NUM_BITS(NUM_BITS),
  .SETTLE_W(SETTLE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .test_en       (test_en),
  .rd_phase      (rd_phase),
  .eval_phase    (eval_phase),
  .settle_cycles (settle_cycles),
  .err_clr       (err_clr),
  .err_flag      (err_flag)
);

// File: tb/tb_bit_coincidence_checker.sv
`timescale 1ns/1ps
module tb_bit_coincidence_checker;
  localparam int NB = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          test_en = 1'b0;
  logic          rd_phase = 1'b0;
  logic          eval_phase = 1'b0;
  logic          grp_even = 1'b0;
  logic [NB-1:0] sense = '0;
  logic [SW-1:0] settle_cycles = '0;
  logic          err_clr = 1'b0;
  logic          err_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t q[$];

  bit exp_flag = 1'b0;
  int rd_age = 0;

  always #2.5 clk = ~clk;

  bit_coincidence_checker #(.NUM_BITS(NB), .SETTLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .rd_phase(rd_phase),
    .eval_phase(eval_phase), .grp_even(grp_even), .sense(sense),
    .settle_cycles(settle_cycles), .err_clr(err_clr), .err_flag(err_flag)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: err_flag=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic step(input bit te, input bit rd, input bit ev, input bit ge,
                      input logic [NB-1:0] s, input bit clr, input int stl,
                      input string tag);
    bit ones, zeros, mixed, settled;
    item_t it;
    @(negedge clk);
    test_en = te; rd_phase = rd; eval_phase = ev; grp_even = ge;
    sense = s; err_clr = clr; settle_cycles = SW'(stl);
    ones = 1'b1; zeros = 1'b1;
    for (int i = (ge ? 0 : 1); i < NB; i += 2) begin
      if (s[i]) zeros = 1'b0; else ones = 1'b0;
    end
    mixed = !(ones || zeros);
    settled = rd_age >= stl;
    if (!te || !rd || clr) exp_flag = 1'b0;
    else if (ev && settled && mixed) exp_flag = 1'b1;
    rd_age = (!te || !rd) ? 0 : rd_age + 1;
    it.exp = exp_flag; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(err_flag, it.exp, it.tag);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(err_flag, 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(err_flag, 1'b0, "R1 post-reset");

    // unanimous groups
    step(1, 1, 1, 1, 16'h5555, 0, 0, "R3 even all ones");
    step(1, 1, 1, 0, 16'h5555, 0, 0, "R4 odd all zeros");
    step(1, 1, 1, 1, 16'hAAAA, 0, 0, "R4 even all zeros");
    step(1, 1, 1, 0, 16'hFFFF, 0, 0, "R3 odd all ones");
    // unselected group flipped
    step(1, 1, 1, 0, 16'hAAAB, 0, 0, "R6 even bit0 disturbs nothing");
    step(1, 1, 1, 1, 16'h7555, 0, 0, "R6 odd bit13 disturbs nothing");
    // precharge ignores mismatch
    step(1, 1, 0, 1, 16'h5554, 0, 0, "R11 precharge mismatch");
    // mismatch in even group
    step(1, 1, 1, 1, 16'h5554, 0, 0, "R5 R2 even mismatch sets");
    step(1, 1, 0, 1, 16'h5555, 0, 0, "R7 sticky precharge");
    step(1, 1, 1, 1, 16'h5555, 0, 0, "R7 sticky unanimous");
    step(1, 0, 0, 1, 16'h5555, 0, 0, "R9 write clears");
    step(1, 0, 1, 1, 16'h5554, 0, 0, "R9 write blocks set");
    // odd group mismatch
    step(1, 1, 1, 0, 16'h2AAA, 0, 0, "R5 R2 odd mismatch sets");
    step(1, 1, 1, 0, 16'hAAAA, 1, 0, "R8 explicit clear");
    step(1, 1, 1, 0, 16'h2AAA, 1, 0, "R8 clear beats mismatch");
    step(0, 1, 1, 0, 16'h2AAA, 0, 0, "R10 idle blocks set");
    step(0, 0, 0, 0, 16'h0000, 0, 0, "R10 idle");
    // settle window of 3
    step(1, 1, 1, 1, 16'h5554, 0, 3, "R12 age0 ignored");
    step(1, 1, 1, 1, 16'h5554, 0, 3, "R12 age1 ignored");
    step(1, 1, 1, 1, 16'h5554, 0, 3, "R12 age2 ignored");
    step(1, 1, 1, 1, 16'h5554, 0, 3, "R12 age3 sets");
    step(1, 1, 1, 1, 16'h5555, 0, 3, "R7 sticky after window");
    step(0, 0, 0, 1, 16'h5555, 0, 3, "R10 test exit clears");
    step(1, 1, 1, 1, 16'h5554, 0, 1, "R12 new read age0 ignored");
    step(1, 1, 1, 1, 16'h5554, 0, 1, "R12 age1 sets");
    step(1, 0, 0, 1, 16'h0000, 0, 0, "R9 final clear");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule